// File: doc/BRIEF.md
# Repeated-Bit Read Sampler with Adaptive Rate

This block carries read data across a serial line while the line timing is still being recalibrated after a wake-up from a deep low-power state. While the calibrating flag is high, every data bit is held on the line for Z consecutive unit intervals (one interval per clock). The receiver takes a single sample near the middle of that widened window, so a skewed sampling point still lands on stable data. Once calibration ends, words go back to one interval per bit.

The factor Z is a power of two from 1 to 8, carried as a two-bit log value. At the start of each calibration window Z is loaded from a configuration input. If a downstream checker flags an error while calibration is active, Z doubles and the last word is sent again. Z does not drop back to full rate. A word never changes its own rate: a new Z, set by calibration ending, a new window or an error, takes effect on the next word. The matching transmit-side repeater sits in the same block. It shares the rate register with the receiver, so a test can loop the line back onto itself.

A word is sent least significant bit first. A frame indicator marks the first unit interval of each word. The receiver needs this indicator to coincide with the first interval it sees on its line input.

Top module: `rep_rate_sampler`

## Requirements
- R1: A word loaded while `cal_active` is high uses Z = 2^zlog unit intervals per bit. A word loaded while it is low uses Z = 1. From the loading clock edge to the edge that raises `rx_valid`, a looped-back word takes exactly DATA_W*Z cycles. `zlog_out` shows the log of the Z used by the word most recently loaded.
- R2: In each bit the receiver samples the interval with index Z/2, counted from 0, and index 0 when Z = 1. The line value in any other interval has no effect on `rx_data`.
- R3: Bit 0 of `tx_data` is sent first. `rx_data` equals the transmitted word. `rx_valid` is a single-cycle pulse once per word.
- R4: On the first cycle in which `cal_active` is seen high after being low, the rate log is loaded from `cfg_zlog`. The codes 0, 1, 2 and 3 mean Z = 1, 2, 4 and 8.
- R5: An `err_det` pulse while `cal_active` is high increments the rate log, saturating at 3 (Z = 8). It makes the transmitter resend the previous word. `tx_ready` stays low until that resend is loaded.
- R6: An `err_det` pulse while `cal_active` is low is ignored: `tx_ready` stays high, no word is resent, and the next word runs at Z = 1.
- R7: Z changes only at word boundaries. If `cal_active` falls while a word is in flight, that word keeps its Z, and the following word uses Z = 1.
- R8: After reset `tx_ready` is 1, while `rx_valid`, `line_out` and `zlog_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one unit interval per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cal_active | input | 1 | High while the line is recalibrating |
| cfg_zlog | input | 2 | Rate log loaded at the start of a calibration window |
| err_det | input | 1 | Error reported for the last received word |
| tx_data | input | DATA_W | Word to transmit |
| tx_valid | input | 1 | Request to load `tx_data` |
| tx_ready | output | 1 | Transmitter idle with no resend pending |
| line_out | output | 1 | Serial line from the repeater |
| tx_frame | output | 1 | High during the first unit interval of each word |
| line_in | input | 1 | Serial line into the sampler |
| rx_frame | input | 1 | Marks the first unit interval of a word on `line_in` |
| rx_data | output | DATA_W | Received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| zlog_out | output | 2 | Rate log of the word most recently loaded |

## Verification
A table of words is looped back under each rate code, with calibration both on and off. The bit patterns mix alternating, single-edge, all-ones and all-zeros values. This separates a wrong bit order or a dropped interval from a wrong latency. Glitches are then forced on every interval except the one that should be sampled, and then only on that one. The first run must leave the data intact and the second must invert it, which pins the sample index. Directed sequences then chain errors up to saturation, start a fresh window after doubling, send an error outside calibration, and drop calibration mid-word. These separate the word-boundary rule from an immediate rate change.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int ZLOG_BITS = 2;
  typedef logic [ZLOG_BITS-1:0] zlog_t;
  typedef enum logic {RX_IDLE, RX_RUN} rx_state_t;
endpackage

// File: rtl/rrs_rate_ctrl.sv
module rrs_rate_ctrl
  import rrs_pkg::*;
#(
  parameter int ZLOG_MAX = 3,
  parameter int DEF_ZLOG = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cal_active,
  input  zlog_t cfg_zlog,
  input  logic  err_det,
  output zlog_t word_zlog,
  output logic  err_accept
);
  localparam zlog_t MAX_Z = zlog_t'(ZLOG_MAX);

  logic  cal_q;
  zlog_t target_q;
  logic  cal_rise;
  zlog_t cfg_c;
  zlog_t base;

  // new window: take configured value, clipped to the supported maximum
  assign cal_rise   = cal_active & ~cal_q;
  assign cfg_c      = (cfg_zlog > MAX_Z) ? MAX_Z : cfg_zlog;
  assign base       = cal_rise ? cfg_c : target_q;
  assign word_zlog  = cal_active ? base : '0;
  assign err_accept = err_det & cal_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q    <= 1'b0;
      target_q <= zlog_t'(DEF_ZLOG);
    end else begin
      cal_q <= cal_active;
      if (err_accept)
        target_q <= (base == MAX_Z) ? MAX_Z : base + zlog_t'(1);
      else if (cal_rise)
        target_q <= cfg_c;
    end
  end
endmodule

// File: rtl/rrs_repeater_tx.sv
module rrs_repeater_tx
  import rrs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ZLOG_MAX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  zlog_t             word_zlog,
  input  logic              retry_req,
  output logic              tx_ready,
  output logic              line_out,
  output logic              frame,
  output logic              busy,
  output zlog_t             zlog_out
);
  localparam int UI_W  = (ZLOG_MAX > 0) ? ZLOG_MAX : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] shreg_q;
  logic [UI_W-1:0]   ui_q;
  logic [BIT_W-1:0]  bit_q;
  logic              retry_q;
  logic              load;
  logic [DATA_W-1:0] word;
  logic [UI_W-1:0]   ui_last;

  assign load     = ~busy & (retry_q | tx_valid);
  assign word     = retry_q ? hold_q : tx_data;
  assign ui_last  = UI_W'((32'd1 << zlog_out) - 32'd1);
  assign tx_ready = ~busy & ~retry_q;
  assign line_out = shreg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      frame    <= 1'b0;
      retry_q  <= 1'b0;
      hold_q   <= '0;
      shreg_q  <= '0;
      ui_q     <= '0;
      bit_q    <= '0;
      zlog_out <= '0;
    end else begin
      // a fresh error wins over a resend that loads in the same cycle
      if (retry_req)
        retry_q <= 1'b1;
      else if (load)
        retry_q <= 1'b0;

      if (load) begin
        busy     <= 1'b1;
        frame    <= 1'b1;
        hold_q   <= word;
        shreg_q  <= word;
        ui_q     <= '0;
        bit_q    <= '0;
        zlog_out <= word_zlog;
      end else begin
        frame <= 1'b0;
        if (busy) begin
          if (ui_q == ui_last) begin
            ui_q    <= '0;
            shreg_q <= shreg_q >> 1;
            if (bit_q == LAST_BIT)
              busy <= 1'b0;
            else
              bit_q <= bit_q + BIT_W'(1);
          end else begin
            ui_q <= ui_q + UI_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rrs_sampler_rx.sv
module rrs_sampler_rx
  import rrs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ZLOG_MAX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  input  logic              frame,
  input  zlog_t             zlog_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int UI_W  = (ZLOG_MAX > 0) ? ZLOG_MAX : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_t         state_q;
  zlog_t             z_q;
  logic [UI_W-1:0]   ui_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shreg_q;

  zlog_t             cur_z;
  logic [UI_W-1:0]   cur_ui;
  logic [BIT_W-1:0]  cur_bit;
  logic              run;
  logic [UI_W-1:0]   samp_idx;
  logic [UI_W-1:0]   ui_last;
  logic              take;
  logic              bit_end;
  logic              word_end;
  logic [DATA_W-1:0] shreg_n;

  // the frame indicator restarts counting on the interval it marks
  always_comb begin
    cur_z    = frame ? zlog_in : z_q;
    cur_ui   = frame ? '0 : ui_q;
    cur_bit  = frame ? '0 : bit_q;
    run      = frame | (state_q == RX_RUN);
    samp_idx = (cur_z == '0) ? '0 : UI_W'(32'd1 << (cur_z - zlog_t'(1)));
    ui_last  = UI_W'((32'd1 << cur_z) - 32'd1);
    take     = run & (cur_ui == samp_idx);
    bit_end  = run & (cur_ui == ui_last);
    word_end = bit_end & (cur_bit == LAST_BIT);
    shreg_n  = take ? {line_in, shreg_q[DATA_W-1:1]} : shreg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RX_IDLE;
      z_q      <= '0;
      ui_q     <= '0;
      bit_q    <= '0;
      shreg_q  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= word_end;
      shreg_q  <= shreg_n;
      z_q      <= cur_z;
      if (word_end)
        rx_data <= shreg_n;
      if (run) begin
        state_q <= word_end ? RX_IDLE : RX_RUN;
        if (bit_end) begin
          ui_q  <= '0;
          bit_q <= cur_bit + BIT_W'(1);
        end else begin
          ui_q  <= cur_ui + UI_W'(1);
          bit_q <= cur_bit;
        end
      end
    end
  end
endmodule

// File: rtl/rep_rate_sampler.sv
module rep_rate_sampler
  import rrs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ZLOG_MAX = 3,
  parameter int DEF_ZLOG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_active,
  input  logic [1:0]        cfg_zlog,
  input  logic              err_det,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              line_out,
  output logic              tx_frame,
  input  logic              line_in,
  input  logic              rx_frame,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [1:0]        zlog_out
);
  zlog_t word_zlog;
  logic  err_accept;
  logic  tx_busy;

  rrs_rate_ctrl #(.ZLOG_MAX(ZLOG_MAX), .DEF_ZLOG(DEF_ZLOG)) u_rate (
    .clk(clk), .rst(rst), .cal_active(cal_active), .cfg_zlog(cfg_zlog),
    .err_det(err_det), .word_zlog(word_zlog), .err_accept(err_accept)
  );

  rrs_repeater_tx #(.DATA_W(DATA_W), .ZLOG_MAX(ZLOG_MAX)) u_tx (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .word_zlog(word_zlog), .retry_req(err_accept), .tx_ready(tx_ready),
    .line_out(line_out), .frame(tx_frame), .busy(tx_busy), .zlog_out(zlog_out)
  );

  rrs_sampler_rx #(.DATA_W(DATA_W), .ZLOG_MAX(ZLOG_MAX)) u_rx (
    .clk(clk), .rst(rst), .line_in(line_in), .frame(rx_frame),
    .zlog_in(zlog_out), .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int ZLOG_MAX = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       cal_active,
  input logic [1:0] cfg_zlog,
  input logic       err_det,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_busy,
  input logic       tx_frame,
  input logic [1:0] zlog_out,
  input logic       rx_valid
);
  localparam logic [1:0] MAX_Z = 2'(ZLOG_MAX);

  assert_full_rate_R1: assert property (@(posedge clk) disable iff (rst)
    tx_frame |-> ($past(cal_active) || zlog_out == 2'd0));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_window_load_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_frame && $past(cal_active) && !$past(cal_active, 2)) |->
      zlog_out == (($past(cfg_zlog) > MAX_Z) ? MAX_Z : $past(cfg_zlog)));

  assert_retry_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (err_det && cal_active) |=> !tx_ready);

  assert_err_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (err_det && !cal_active && tx_ready && !tx_valid) |=> tx_ready);

  assert_rate_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && $past(tx_busy)) |-> $stable(zlog_out));
endmodule

bind rep_rate_sampler rrs_checker #(.ZLOG_MAX(ZLOG_MAX)) u_chk (
  .clk(clk), .rst(rst), .cal_active(cal_active), .cfg_zlog(cfg_zlog),
  .err_det(err_det), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_busy(tx_busy), .tx_frame(tx_frame), .zlog_out(zlog_out),
  .rx_valid(rx_valid)
);

// File: tb/rep_rate_sampler_tb_top.sv
`timescale 1ns/1ps
module rep_rate_sampler_tb_top;
  localparam int W = 8;
  localparam int NVEC = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_active = 1'b0;
  logic [1:0] cfg_zlog = 2'd1;
  logic err_det = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic flip = 1'b0;
  logic tx_ready, line_out, tx_frame, rx_valid;
  logic [W-1:0] rx_data;
  logic [1:0] zlog_out;
  logic line_in;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  assign line_in = line_out ^ flip;

  always #4 clk = ~clk;

  rep_rate_sampler #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .cal_active(cal_active), .cfg_zlog(cfg_zlog),
    .err_det(err_det), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .line_out(line_out), .tx_frame(tx_frame),
    .line_in(line_in), .rx_frame(tx_frame), .rx_data(rx_data),
    .rx_valid(rx_valid), .zlog_out(zlog_out)
  );

  // {data[8], cal, cfg[2], Z[4]}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hA5, 1'b1, 2'd1, 4'd2},
    {8'h3C, 1'b0, 2'd2, 4'd1},
    {8'h81, 1'b1, 2'd0, 4'd1},
    {8'h5A, 1'b1, 2'd2, 4'd4},
    {8'hFF, 1'b1, 2'd3, 4'd8},
    {8'h00, 1'b1, 2'd1, 4'd2},
    {8'h69, 1'b0, 2'd3, 4'd1}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // called at a negedge; leaves cal/cfg set for a fresh window
  task automatic new_window(input logic cal, input logic [1:0] cfg);
    cal_active = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cal_active = cal;
    cfg_zlog = cfg;
  endtask

  // called at the negedge after the loading edge
  task automatic wait_word(input logic [W-1:0] d, input int z, input int mode,
                           input int drop_at, input string req);
    int cnt = 0;
    logic [W-1:0] exp_d;
    exp_d = (mode == 2) ? ~d : d;
    while (!rx_valid && cnt < 2000) begin
      flip = 1'b0;
      if (cnt < W * z) begin
        if (mode == 1 && (cnt % z) != (z / 2)) flip = 1'b1;
        if (mode == 2 && (cnt % z) == (z / 2)) flip = 1'b1;
      end
      if (cnt == drop_at) cal_active = 1'b0;
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    flip = 1'b0;
    chk({req, " latency"}, cnt, W * z);
    chk({req, " data"}, int'(rx_data), int'(exp_d));
    @(posedge clk);
    @(negedge clk);
    chk({req, " R3 valid pulse"}, int'(rx_valid), 0);
  endtask

  task automatic xfer(input logic [W-1:0] d, input int z, input int mode,
                      input int drop_at, input string req);
    int guard = 0;
    while (!tx_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    tx_data = d;
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_word(d, z, mode, drop_at, req);
  endtask

  task automatic retry(input logic [W-1:0] d, input int z, input string req);
    err_det = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err_det = 1'b0;
    chk({req, " R5 ready low"}, int'(tx_ready), 0);
    @(posedge clk);
    @(negedge clk);
    wait_word(d, z, 0, -1, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8 tx_ready", int'(tx_ready), 1);
    chk("R8 rx_valid", int'(rx_valid), 0);
    chk("R8 line_out", int'(line_out), 0);
    chk("R8 zlog_out", int'(zlog_out), 0);

    // R1 R3 R4: table of words under each rate code
    for (int i = 0; i < NVEC; i++) begin
      new_window(VEC[i][6], VEC[i][5:4]);
      xfer(VEC[i][14:7], int'(VEC[i][3:0]), 0, -1, "R1 R3 R4 vector");
    end

    // R5: chained errors double Z, then saturate at 8
    new_window(1'b1, 2'd1);
    xfer(8'hC3, 2, 0, -1, "R5 first");
    retry(8'hC3, 4, "R5 double");
    chk("R5 zlog", int'(zlog_out), 2);
    retry(8'hC3, 8, "R5 double again");
    retry(8'hC3, 8, "R5 saturate");
    chk("R5 zlog sat", int'(zlog_out), 3);

    // R4: a fresh window reloads the configured rate
    new_window(1'b1, 2'd1);
    xfer(8'h2D, 2, 0, -1, "R4 window restart");

    // R6: error outside calibration is ignored
    cal_active = 1'b0;
    err_det = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err_det = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 tx_ready", int'(tx_ready), 1);
    chk("R6 no resend", int'(tx_frame), 0);
    xfer(8'h96, 1, 0, -1, "R6 next word");

    // R7: calibration ends mid-word
    new_window(1'b1, 2'd2);
    xfer(8'h4B, 4, 0, 5, "R7 in flight");
    xfer(8'hB4, 1, 0, -1, "R7 after drop");

    // R2: glitches off the sample interval are ignored, on it they land
    new_window(1'b1, 2'd2);
    xfer(8'hE1, 4, 1, -1, "R2 off-sample glitch");
    new_window(1'b1, 2'd3);
    xfer(8'h1E, 8, 1, -1, "R2 off-sample glitch Z8");
    new_window(1'b1, 2'd2);
    xfer(8'h77, 4, 2, -1, "R2 on-sample glitch");
    new_window(1'b1, 2'd1);
    xfer(8'hC6, 2, 1, -1, "R2 off-sample glitch Z2");

    finish_run();
  end
endmodule